// File: doc/BRIEF.md
# Burst Command Planner for a Continuous-Burst Read Memory

This block turns bus transfers from a pipelined system-bus master into start commands for a read engine. The engine drives a memory that runs in continuous-burst mode. Each command gives a start address, a word count and a prefetch depth. The engine latches the start address, waits out the memory latency and then streams words until it is stopped. A word count of zero means the burst is open-ended. Because the memory never wraps its own address, the planner splits a wrapping burst that starts off the wrap boundary into two linear commands. The first command runs from the start address to the end of the wrap window. The second runs from the window base back up to the start.

The planner also chooses the prefetch behaviour. Bursts of known length fetch nothing beyond their last beat. Open-ended bursts fetch one or two words ahead, as set by a configuration input. A burst of known length that the master interrupts with a BUSY beat becomes open-ended from that point on. Whenever a command can leave words on the external data bus, the planner raises a data-floating flag toward the external bus interface. That flag stays up until the engine reports that the burst has ended.

Top module: `burst_cmd_planner`

## Requirements
- R1: While rst_ni is low, cmd_valid_o, cmd_addr_o, cmd_len_o, cmd_pf_o and float_o are all zero.
- R2: A NONSEQ beat (htrans_i=2) with hburst_i=0 (single) produces, one clock later, one command with cmd_addr_o equal to that beat's address, cmd_len_o=1 and cmd_pf_o=0.
- R3: A NONSEQ beat with hburst_i=3, 5 or 7 (incrementing 4, 8 or 16 beats) produces one command at the beat's address, with cmd_len_o set to 4, 8 or 16 and cmd_pf_o=0.
- R4: A NONSEQ beat with hburst_i=1 (incrementing, length unknown) produces one command at the beat's address with cmd_len_o=0. Its cmd_pf_o is 1 when pf_depth_i=0 and 2 when pf_depth_i=1. The same edge sets float_o.
- R5: A NONSEQ beat with hburst_i=2, 4 or 6 (wrapping 4, 8 or 16 beats) whose address is aligned to the wrap window produces one command with cmd_len_o equal to the beat count and cmd_pf_o=0. The wrap window is the beat count times 2^hsize_i bytes.
- R6: For a wrapping burst that starts k beats (k>0) into its window, the next cycle issues a command at the start address with length (beats-k). The cycle after that issues a command at the window base with length k and cmd_pf_o=0, and that second command sets float_o.
- R7: In an incrementing 4, 8 or 16 beat burst, the first SEQ beat (htrans_i=3) after a BUSY beat (htrans_i=1) issues a command at that SEQ beat's address with cmd_len_o=0 and the prefetch depth from R4. It sets float_o, and the rest of the burst is treated as length-unknown.
- R8: In a length-unknown burst, a SEQ beat whose address has its low PAGE_W bits all zero issues a command at that address with cmd_len_o=0 and the prefetch depth from R4.
- R9: Once set, float_o stays high until a cycle with eng_done_i high, which clears it on the next edge. A command that sets float_o on the same edge wins over eng_done_i.
- R10: A NONSEQ beat in the cycle where the second command of a split wrap is due drops that second command. The new beat's command is issued instead.
- R11: IDLE beats (htrans_i=0), BUSY beats and SEQ beats that meet none of the conditions in R6 to R8 issue no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| htrans_i | input | 2 | Transfer type: 0 idle, 1 busy, 2 nonseq, 3 seq |
| hburst_i | input | 3 | Burst type: 0 single, 1 incr, 2 wrap4, 3 incr4, 4 wrap8, 5 incr8, 6 wrap16, 7 incr16 |
| haddr_i | input | AW | Byte address of the current beat |
| hsize_i | input | 3 | Log2 of the beat size in bytes |
| pf_depth_i | input | 1 | Prefetch depth for length-unknown bursts: 0 means one word, 1 means two |
| eng_done_i | input | 1 | Engine reports that the running device burst has terminated |
| cmd_valid_o | output | 1 | A new initial-burst command is presented this cycle |
| cmd_addr_o | output | AW | Start byte address of the command |
| cmd_len_o | output | 5 | Word count; 0 means open-ended |
| cmd_pf_o | output | 2 | Words the engine may read ahead of the bus |
| float_o | output | 1 | Data may float on the external bus; the next external access will be delayed |

## Verification
Two pairs of functions can land on the same edge. The first pair is the second half of a split wrap and a fresh NONSEQ beat. The bench provokes it by starting a new transfer one cycle after an unaligned wrap, and it expects only the new transfer's command. The second pair is float_o being set by a command and being cleared by eng_done_i. The bench raises eng_done_i in the same cycle as an open-ended NONSEQ beat and expects float_o to stay high. A behavioural model in the bench predicts every command and the flag on each clock, including the split lengths of wrap windows with different beat sizes and the command that follows a BUSY break.

// File: rtl/burst_cmd_planner_pkg.sv
package burst_cmd_planner_pkg;
  typedef enum logic [1:0] {TR_IDLE = 2'd0, TR_BUSY = 2'd1, TR_NONSEQ = 2'd2, TR_SEQ = 2'd3} trans_e;
  typedef enum logic [2:0] {
    BU_SINGLE = 3'd0, BU_INCR = 3'd1, BU_WRAP4 = 3'd2, BU_INCR4 = 3'd3,
    BU_WRAP8 = 3'd4, BU_INCR8 = 3'd5, BU_WRAP16 = 3'd6, BU_INCR16 = 3'd7
  } burst_e;
  localparam int unsigned LEN_W = 5;
  localparam int unsigned PF_W  = 2;
endpackage

// File: rtl/beat_decode.sv
module beat_decode
  import burst_cmd_planner_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [2:0]       burst_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [2:0]       size_i,
  output logic [LEN_W-1:0] beats_o,
  output logic             wrap_o,
  output logic             fixed_incr_o,
  output logic             split_o,
  output logic [LEN_W-1:0] len_a_o,
  output logic [LEN_W-1:0] len_b_o,
  output logic [AW-1:0]    base_o
);
  logic [AW-1:0] win_mask;
  logic [AW-1:0] off_full;

  always_comb begin
    unique case (burst_e'(burst_i))
      BU_SINGLE:           beats_o = LEN_W'(1);
      BU_INCR:             beats_o = '0;
      BU_WRAP4, BU_INCR4:  beats_o = LEN_W'(4);
      BU_WRAP8, BU_INCR8:  beats_o = LEN_W'(8);
      default:             beats_o = LEN_W'(16);
    endcase
    wrap_o       = (burst_i == BU_WRAP4) || (burst_i == BU_WRAP8) || (burst_i == BU_WRAP16);
    fixed_incr_o = (burst_i == BU_INCR4) || (burst_i == BU_INCR8) || (burst_i == BU_INCR16);
    win_mask     = (AW'(beats_o) << size_i) - AW'(1);
    off_full     = (addr_i & win_mask) >> size_i;
    base_o       = addr_i & ~win_mask;
    split_o      = wrap_o && (off_full != '0);
    len_b_o      = off_full[LEN_W-1:0];
    len_a_o      = split_o ? beats_o - len_b_o : beats_o;
  end
endmodule

// File: rtl/burst_tracker.sv
module burst_tracker
  import burst_cmd_planner_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned PAGE_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       htrans_i,
  input  logic [2:0]       hburst_i,
  input  logic [AW-1:0]    haddr_i,
  input  logic [2:0]       hsize_i,
  input  logic             pf_depth_i,
  output logic             issue_o,
  output logic [AW-1:0]    addr_o,
  output logic [LEN_W-1:0] len_o,
  output logic [PF_W-1:0]  pf_o,
  output logic             float_set_o
);
  logic [LEN_W-1:0] beats, len_a, len_b;
  logic             wrap, fixed_incr, split;
  logic [AW-1:0]    base;

  beat_decode #(.AW(AW)) u_dec (
    .burst_i(hburst_i), .addr_i(haddr_i), .size_i(hsize_i),
    .beats_o(beats), .wrap_o(wrap), .fixed_incr_o(fixed_incr), .split_o(split),
    .len_a_o(len_a), .len_b_o(len_b), .base_o(base)
  );

  logic             active_q, open_q, fixed_q, busy_q, pend_q;
  logic [AW-1:0]    pend_addr_q;
  logic [LEN_W-1:0] pend_len_q;

  logic             is_nonseq, is_seq, page_hit, brk_hit, open_cmd;
  logic [PF_W-1:0]  spec_pf;

  assign is_nonseq = (htrans_i == TR_NONSEQ);
  assign is_seq    = (htrans_i == TR_SEQ);
  assign page_hit  = (haddr_i[PAGE_W-1:0] == '0);
  assign spec_pf   = pf_depth_i ? PF_W'(2) : PF_W'(1);
  assign brk_hit   = is_seq && active_q && fixed_q && busy_q;
  assign open_cmd  = !is_nonseq && !pend_q &&
                     (brk_hit || (is_seq && active_q && open_q && page_hit));

  // priority: new transfer, pending wrap tail, break / page restart
  always_comb begin
    issue_o     = 1'b0;
    addr_o      = haddr_i;
    len_o       = '0;
    pf_o        = '0;
    float_set_o = 1'b0;
    if (is_nonseq) begin
      issue_o = 1'b1;
      len_o   = len_a;
      if (hburst_i == BU_INCR) begin
        pf_o        = spec_pf;
        float_set_o = 1'b1;
      end
    end else if (pend_q) begin
      issue_o     = 1'b1;
      addr_o      = pend_addr_q;
      len_o       = pend_len_q;
      float_set_o = 1'b1;
    end else if (open_cmd) begin
      issue_o     = 1'b1;
      pf_o        = spec_pf;
      float_set_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      open_q      <= 1'b0;
      fixed_q     <= 1'b0;
      busy_q      <= 1'b0;
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_len_q  <= '0;
    end else begin
      if (is_nonseq) begin
        active_q    <= 1'b1;
        open_q      <= (hburst_i == BU_INCR);
        fixed_q     <= fixed_incr;
        busy_q      <= 1'b0;
        pend_q      <= split;
        pend_addr_q <= base;
        pend_len_q  <= len_b;
      end else begin
        pend_q <= 1'b0;
        if (brk_hit && !pend_q) begin
          open_q  <= 1'b1;
          fixed_q <= 1'b0;
          busy_q  <= 1'b0;
        end
        if (htrans_i == TR_IDLE) begin
          active_q <= 1'b0;
          busy_q   <= 1'b0;
        end else if (htrans_i == TR_BUSY && active_q && fixed_q) begin
          busy_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/float_track.sv
module float_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic float_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    float_o <= 1'b0;
    else if (set_i) float_o <= 1'b1;
    else if (clr_i) float_o <= 1'b0;
  end
endmodule

// File: rtl/burst_cmd_planner.sv
module burst_cmd_planner
  import burst_cmd_planner_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned PAGE_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       htrans_i,
  input  logic [2:0]       hburst_i,
  input  logic [AW-1:0]    haddr_i,
  input  logic [2:0]       hsize_i,
  input  logic             pf_depth_i,
  input  logic             eng_done_i,
  output logic             cmd_valid_o,
  output logic [AW-1:0]    cmd_addr_o,
  output logic [LEN_W-1:0] cmd_len_o,
  output logic [PF_W-1:0]  cmd_pf_o,
  output logic             float_o
);
  logic             issue, fset;
  logic [AW-1:0]    n_addr;
  logic [LEN_W-1:0] n_len;
  logic [PF_W-1:0]  n_pf;

  burst_tracker #(.AW(AW), .PAGE_W(PAGE_W)) u_trk (
    .clk_i, .rst_ni, .htrans_i, .hburst_i, .haddr_i, .hsize_i, .pf_depth_i,
    .issue_o(issue), .addr_o(n_addr), .len_o(n_len), .pf_o(n_pf), .float_set_o(fset)
  );

  float_track u_flt (.clk_i, .rst_ni, .set_i(fset), .clr_i(eng_done_i), .float_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o <= 1'b0;
      cmd_addr_o  <= '0;
      cmd_len_o   <= '0;
      cmd_pf_o    <= '0;
    end else begin
      cmd_valid_o <= issue;
      cmd_addr_o  <= issue ? n_addr : '0;
      cmd_len_o   <= issue ? n_len  : '0;
      cmd_pf_o    <= issue ? n_pf   : '0;
    end
  end
endmodule

// File: rtl/burst_cmd_planner_chk.sv
module burst_cmd_planner_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    htrans_i,
  input logic [2:0]    hburst_i,
  input logic [AW-1:0] haddr_i,
  input logic          pf_depth_i,
  input logic          eng_done_i,
  input logic          cmd_valid_o,
  input logic [AW-1:0] cmd_addr_o,
  input logic [4:0]    cmd_len_o,
  input logic [1:0]    cmd_pf_o,
  input logic          float_o
);
  p_single_cmd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_i == 2'd2 && hburst_i == 3'd0) |=>
      (cmd_valid_o && cmd_len_o == 5'd1 && cmd_pf_o == 2'd0 && cmd_addr_o == $past(haddr_i)));

  p_incr4_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_i == 2'd2 && hburst_i == 3'd3) |=> (cmd_valid_o && cmd_len_o == 5'd4 && cmd_pf_o == 2'd0));

  p_open_pf_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_i == 2'd2 && hburst_i == 3'd1) |=>
      (cmd_valid_o && cmd_len_o == 5'd0 && float_o &&
       cmd_pf_o == ($past(pf_depth_i) ? 2'd2 : 2'd1)));

  p_pf_floats_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_pf_o != 2'd0) |-> float_o);

  p_float_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (float_o && !eng_done_i) |=> float_o);
endmodule

bind burst_cmd_planner burst_cmd_planner_chk #(.AW(AW)) i_chk (.*);

// File: tb/test_burst_cmd_planner.sv
module test_burst_cmd_planner;
  localparam int AW = 32;
  localparam int PAGE_W = 10;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    htrans_i = '0;
  logic [2:0]    hburst_i = '0;
  logic [AW-1:0] haddr_i = '0;
  logic [2:0]    hsize_i = 3'd2;
  logic          pf_depth_i = 1'b0;
  logic          eng_done_i = 1'b0;
  logic          cmd_valid_o;
  logic [AW-1:0] cmd_addr_o;
  logic [4:0]    cmd_len_o;
  logic [1:0]    cmd_pf_o;
  logic          float_o;

  burst_cmd_planner #(.AW(AW), .PAGE_W(PAGE_W)) i_burst_cmd_planner (.*);

  always #4 clk_i = ~clk_i;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  // behavioural reference
  bit      e_valid = 0, e_float = 0;
  longint  e_addr = 0;
  int      e_len = 0, e_pf = 0;
  string   e_tag = "R1";
  bit      m_active = 0, m_open = 0, m_fixed = 0, m_busy = 0, m_pend = 0;
  longint  m_paddr = 0;
  int      m_plen = 0;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      e_valid = 0; e_float = 0; e_addr = 0; e_len = 0; e_pf = 0; e_tag = "R1";
      m_active = 0; m_open = 0; m_fixed = 0; m_busy = 0; m_pend = 0;
    end else begin
      automatic int  spec = pf_depth_i ? 2 : 1;
      automatic bit  fset = 0;
      automatic bit  was_pend = m_pend;
      e_valid = 0; e_addr = 0; e_len = 0; e_pf = 0; e_tag = "R11";
      m_pend = 0;
      if (htrans_i == 2) begin
        automatic int n = (hburst_i == 0) ? 1 : (hburst_i == 1) ? 0 :
                          (hburst_i <= 3) ? 4 : (hburst_i <= 5) ? 8 : 16;
        e_valid = 1; e_addr = haddr_i; m_active = 1; m_busy = 0;
        m_open = (hburst_i == 1); m_fixed = (hburst_i == 3 || hburst_i == 5 || hburst_i == 7);
        if (hburst_i == 0) begin e_len = 1; e_tag = "R2"; end
        else if (hburst_i == 1) begin e_len = 0; e_pf = spec; fset = 1; e_tag = "R4"; end
        else if (m_fixed) begin e_len = n; e_tag = "R3"; end
        else begin
          automatic longint win = longint'(n) << hsize_i;
          automatic int off = int'((longint'(haddr_i) % win) >> hsize_i);
          if (off == 0) begin e_len = n; e_tag = "R5"; end
          else begin
            e_len = n - off; e_tag = "R6";
            m_pend = 1; m_paddr = longint'(haddr_i) - (longint'(haddr_i) % win); m_plen = off;
          end
        end
        if (was_pend) e_tag = "R10";
      end else begin
        if (was_pend) begin
          e_valid = 1; e_addr = m_paddr; e_len = m_plen; fset = 1; e_tag = "R6";
        end else if (htrans_i == 3 && m_active && m_fixed && m_busy) begin
          e_valid = 1; e_addr = haddr_i; e_pf = spec; fset = 1; e_tag = "R7";
          m_open = 1; m_fixed = 0; m_busy = 0;
        end else if (htrans_i == 3 && m_active && m_open && (haddr_i % (1 << PAGE_W)) == 0) begin
          e_valid = 1; e_addr = haddr_i; e_pf = spec; fset = 1; e_tag = "R8";
        end
        if (htrans_i == 0) begin m_active = 0; m_busy = 0; end
        else if (htrans_i == 1 && m_active && m_fixed) m_busy = 1;
      end
      if (fset) e_float = 1;
      else if (eng_done_i) e_float = 0;
    end
  end

  always @(negedge clk_i) begin
    if (!done) begin
      checks++;
      if (cmd_valid_o !== e_valid || (e_valid && (cmd_addr_o !== AW'(e_addr) ||
          cmd_len_o !== 5'(e_len) || cmd_pf_o !== 2'(e_pf)))) begin
        errors++;
        $display("FAIL %s: cmd v=%0b a=%h l=%0d p=%0d expected v=%0b a=%h l=%0d p=%0d",
                 e_tag, cmd_valid_o, cmd_addr_o, cmd_len_o, cmd_pf_o,
                 e_valid, AW'(e_addr), e_len, e_pf);
      end
      checks++;
      if (float_o !== e_float) begin
        errors++;
        $display("FAIL %s: float_o=%0b expected %0b", rst_ni ? "R9" : "R1", float_o, e_float);
      end
    end
  end

  task automatic beat(input logic [1:0] tr, input logic [2:0] bu, input logic [AW-1:0] ad,
                      input logic [2:0] sz = 3'd2, input logic dn = 1'b0);
    @(negedge clk_i);
    htrans_i = tr; hburst_i = bu; haddr_i = ad; hsize_i = sz; eng_done_i = dn;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) beat(2'd0, 3'd0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);   // R1 reset state checked here
    rst_ni = 1'b1;
    idle(2);
    // R2 single
    beat(2'd2, 3'd0, 32'h100); idle(2);
    // R3 incr4 / incr16
    beat(2'd2, 3'd3, 32'h200); beat(2'd3, 3'd3, 32'h204); beat(2'd3, 3'd3, 32'h208);
    beat(2'd3, 3'd3, 32'h20C); idle(1);
    beat(2'd2, 3'd7, 32'h300, 3'd1); idle(2);
    // R4 open burst, depth 1 then 2; R9 clear
    beat(2'd2, 3'd1, 32'h500); beat(2'd3, 3'd1, 32'h504); idle(2);
    beat(2'd0, 3'd0, '0, 3'd2, 1'b1); idle(2);
    pf_depth_i = 1'b1;
    beat(2'd2, 3'd1, 32'h600, 3'd2, 1'b1);   // R9: set wins over done
    idle(2);
    beat(2'd0, 3'd0, '0, 3'd2, 1'b1); idle(1);
    // R5 aligned wrap
    beat(2'd2, 3'd2, 32'h40); beat(2'd3, 3'd2, 32'h44); idle(2);
    // R6 split wraps
    beat(2'd2, 3'd2, 32'h0C); beat(2'd3, 3'd2, 32'h00); beat(2'd3, 3'd2, 32'h04);
    beat(2'd3, 3'd2, 32'h08); idle(2);
    beat(2'd0, 3'd0, '0, 3'd2, 1'b1);
    beat(2'd2, 3'd4, 32'h36, 3'd1); beat(2'd3, 3'd4, 32'h38, 3'd1); idle(3);
    beat(2'd2, 3'd6, 32'h1234, 3'd0); idle(3);
    beat(2'd0, 3'd0, '0, 3'd2, 1'b1);
    // R7 busy break in incr8
    pf_depth_i = 1'b0;
    beat(2'd2, 3'd5, 32'h800); beat(2'd3, 3'd5, 32'h804); beat(2'd1, 3'd5, 32'h808);
    beat(2'd1, 3'd5, 32'h808); beat(2'd3, 3'd5, 32'h808); beat(2'd3, 3'd5, 32'h80C);
    beat(2'd1, 3'd5, 32'h810); beat(2'd3, 3'd5, 32'h810); idle(2);
    beat(2'd0, 3'd0, '0, 3'd2, 1'b1);
    // R11 busy in wrap and stray SEQ ignored
    beat(2'd2, 3'd2, 32'h80); beat(2'd1, 3'd2, 32'h84); beat(2'd3, 3'd2, 32'h84);
    idle(1); beat(2'd3, 3'd1, 32'h400); idle(1);
    // R8 page boundary
    pf_depth_i = 1'b1;
    beat(2'd2, 3'd1, 32'h3F8); beat(2'd3, 3'd1, 32'h3FC); beat(2'd3, 3'd1, 32'h400);
    beat(2'd3, 3'd1, 32'h404); idle(2);
    beat(2'd0, 3'd0, '0, 3'd2, 1'b1);
    // R8 after a break
    beat(2'd2, 3'd3, 32'h7F8); beat(2'd1, 3'd3, 32'h7FC); beat(2'd3, 3'd3, 32'h7FC);
    beat(2'd3, 3'd3, 32'h800); idle(2);
    beat(2'd0, 3'd0, '0, 3'd2, 1'b1);
    // R10 new transfer while split tail pending
    beat(2'd2, 3'd2, 32'h08); beat(2'd2, 3'd0, 32'h900); idle(3);
    beat(2'd2, 3'd4, 32'h1C); beat(2'd2, 3'd1, 32'hA00); idle(3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule